// File: doc/BRIEF.md
# Comma Word Aligner

This block sits right after a deserializer whose output has no known character boundary. Each clock it takes ten raw bits, the first-received bit in the most significant position. It looks for the comma control character at every one of the ten bit offsets inside a 20-bit window. The window joins the previous input word and the current one. On a hit it fixes the character boundary and starts counting characters into four-character transmission words. Every valid word begins with a comma.

Acquisition needs three words in a row that each open with a comma at the fixed boundary. Once locked, the block delivers aligned characters and marks the first character of every word. A downstream decoder can flag a code violation on that first character. Four bad word starts in a row, each flagged or not a comma, drop the lock. The block then goes back to searching and delivers nothing until it has re-acquired on fresh commas.

Top module: `comma_word_aligner`

## Requirements
- R1: After reset and before any input, `char_o` is 0 and `word_start_o` and `lock_o` are low.
- R2: Both comma forms are recognised, written first-received bit first: 0011111010 and 1100000101. Either form may lead any word.
- R3: Alignment is found at any bit offset 0 to 9. `data_i[9]` is the earliest bit of an input word, and the search takes the lowest matching offset.
- R4: `lock_o` rises after three consecutive words each start with a comma at the latched offset, four characters apart. It rises in the same cycle that `char_o` shows the third of these commas, and `word_start_o` is high in that cycle.
- R5: During acquisition, a word whose first character is not a comma abandons the attempt and the search restarts. Earlier commas do not count towards lock.
- R6: While `lock_o` is high, `char_o` is the aligned character. A character whose first bit arrives in input word n is on `char_o` after the clock edge that samples input word n+1.
- R7: While locked, `word_start_o` is high exactly on the first character of each word, every fourth cycle, and never while `lock_o` is low.
- R8: A word start is bad when `code_err_i` is high in that cycle or `char_o` is not a comma. `code_err_i` is ignored in all other cycles. Four consecutive bad word starts drop `lock_o` on the next edge. A good word start in between resets the count.
- R9: After a loss, `lock_o` stays low until a fresh acquisition as in R4 succeeds, possibly at a new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 10 | Raw deserialized bits, bit 9 earliest |
| code_err_i | input | 1 | Code violation on the current `char_o`, used only with `word_start_o` |
| char_o | output | 10 | Aligned character |
| word_start_o | output | 1 | First character of a word, while locked |
| lock_o | output | 1 | Word alignment locked |

## Verification
The stream opens with two good words followed by a word with no comma. A design that kept counting across that broken word would lock one word early, and the bench checks the exact cycle of the first lock. Runs of three flagged word starts followed by a good one must keep lock, while four in a row must drop it; a counter that failed to clear on a good word, or that missed `code_err_i`, would lose lock at the wrong word. A three-bit slip in the middle of the stream forces loss through misaligned word starts and then re-acquisition at a new offset. A design with fixed offsets, or one that kept delivering characters during the search, would show the wrong lock, word-start or character values at the cycle-accurate comparison.

// File: rtl/walign_pkg.sv
package walign_pkg;
  localparam int CHAR_W = 10;
  localparam logic [CHAR_W-1:0] COMMA_NEG = 10'b0011111010;
  localparam logic [CHAR_W-1:0] COMMA_POS = 10'b1100000101;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_SYNC    = 2'd2
  } sync_st_e;

  function automatic logic is_comma(logic [CHAR_W-1:0] c);
    return (c == COMMA_NEG) || (c == COMMA_POS);
  endfunction
endpackage

// File: rtl/walign_search.sv
module walign_search
  import walign_pkg::*;
#(
  parameter int OFF_W = $clog2(CHAR_W)
) (
  input  logic [2*CHAR_W-1:0] win_i,
  output logic                hit_o,
  output logic [OFF_W-1:0]    off_o
);
  logic [CHAR_W-1:0] match;

  for (genvar k = 0; k < CHAR_W; k++) begin : g_off
    assign match[k] = is_comma(win_i[2*CHAR_W-1-k -: CHAR_W]);
  end

  // lowest offset wins
  always_comb begin
    off_o = '0;
    for (int k = CHAR_W-1; k >= 0; k--) begin
      if (match[k]) off_o = OFF_W'(k);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/walign_extract.sv
module walign_extract
  import walign_pkg::*;
#(
  parameter int OFF_W = $clog2(CHAR_W)
) (
  input  logic [2*CHAR_W-1:0] win_i,
  input  logic [OFF_W-1:0]    off_i,
  output logic [CHAR_W-1:0]   char_o
);
  logic [2*CHAR_W-1:0] shifted;

  assign shifted = win_i << off_i;
  assign char_o  = shifted[2*CHAR_W-1 -: CHAR_W];
endmodule

// File: rtl/walign_fsm.sv
module walign_fsm
  import walign_pkg::*;
#(
  parameter int WORD_CHARS = 4,
  parameter int LOCK_WORDS = 3,
  parameter int LOSS_WORDS = 4,
  parameter int OFF_W      = $clog2(CHAR_W)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          hit_i,
  input  logic [OFF_W-1:0]              hit_off_i,
  input  logic                          ch_comma_i,
  input  logic                          chk_i,
  input  logic                          chk_bad_i,
  output sync_st_e                      st_q_o,
  output sync_st_e                      st_d_o,
  output logic [OFF_W-1:0]              off_o,
  output logic [$clog2(WORD_CHARS)-1:0] pos_o
);
  localparam int POS_W  = $clog2(WORD_CHARS);
  localparam int GOOD_W = $clog2(LOCK_WORDS + 1);
  localparam int BAD_W  = $clog2(LOSS_WORDS + 1);

  sync_st_e          st_q, st_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic [POS_W-1:0]  pos_q, pos_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic [BAD_W-1:0]  bad_q, bad_d;

  always_comb begin
    st_d   = st_q;
    off_d  = off_q;
    pos_d  = (pos_q == POS_W'(WORD_CHARS-1)) ? '0 : pos_q + 1'b1;
    good_d = good_q;
    bad_d  = bad_q;
    unique case (st_q)
      ST_HUNT: begin
        pos_d = '0;
        if (hit_i) begin
          off_d  = hit_off_i;
          pos_d  = POS_W'(1);
          good_d = GOOD_W'(1);
          st_d   = ST_CONFIRM;
        end
      end
      ST_CONFIRM: begin
        if (pos_q == '0) begin
          if (!ch_comma_i) begin
            st_d = ST_HUNT;
          end else if (good_q == GOOD_W'(LOCK_WORDS-1)) begin
            st_d  = ST_SYNC;
            bad_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end
      ST_SYNC: begin
        // word-start check runs on the registered output character
        if (chk_i) begin
          if (!chk_bad_i)                          bad_d = '0;
          else if (bad_q == BAD_W'(LOSS_WORDS-1)) st_d  = ST_HUNT;
          else                                     bad_d = bad_q + 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      off_q  <= '0;
      pos_q  <= '0;
      good_q <= '0;
      bad_q  <= '0;
    end else begin
      st_q   <= st_d;
      off_q  <= off_d;
      pos_q  <= pos_d;
      good_q <= good_d;
      bad_q  <= bad_d;
    end
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;
  assign off_o  = off_q;
  assign pos_o  = pos_q;
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import walign_pkg::*;
#(
  parameter int WORD_CHARS = 4,
  parameter int LOCK_WORDS = 3,
  parameter int LOSS_WORDS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [9:0]  data_i,
  input  logic        code_err_i,
  output logic [9:0]  char_o,
  output logic        word_start_o,
  output logic        lock_o
);
  localparam int OFF_W = $clog2(CHAR_W);
  localparam int POS_W = $clog2(WORD_CHARS);

  logic [CHAR_W-1:0]   prev_q;
  logic [2*CHAR_W-1:0] win;
  logic                hit;
  logic [OFF_W-1:0]    hit_off, off;
  logic [CHAR_W-1:0]   ch;
  logic [POS_W-1:0]    pos;
  sync_st_e            st_q, st_d;
  logic                chk_bad;

  assign win     = {prev_q, data_i};
  assign chk_bad = code_err_i | ~is_comma(char_o);

  walign_search #(.OFF_W(OFF_W)) u_search (
    .win_i (win),
    .hit_o (hit),
    .off_o (hit_off)
  );

  walign_extract #(.OFF_W(OFF_W)) u_extract (
    .win_i  (win),
    .off_i  (off),
    .char_o (ch)
  );

  walign_fsm #(
    .WORD_CHARS (WORD_CHARS),
    .LOCK_WORDS (LOCK_WORDS),
    .LOSS_WORDS (LOSS_WORDS),
    .OFF_W      (OFF_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hit_i      (hit),
    .hit_off_i  (hit_off),
    .ch_comma_i (is_comma(ch)),
    .chk_i      (word_start_o),
    .chk_bad_i  (chk_bad),
    .st_q_o     (st_q),
    .st_d_o     (st_d),
    .off_o      (off),
    .pos_o      (pos)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= '0;
      char_o       <= '0;
      word_start_o <= 1'b0;
      lock_o       <= 1'b0;
    end else begin
      prev_q       <= data_i;
      char_o       <= ch;
      word_start_o <= (st_d == ST_SYNC) && (st_q != ST_HUNT) && (pos == '0);
      lock_o       <= (st_d == ST_SYNC);
    end
  end
endmodule

// File: rtl/comma_word_aligner_chk.sv
module comma_word_aligner_chk
  import walign_pkg::*;
#(
  parameter int WORD_CHARS = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [9:0] char_o,
  input logic       word_start_o,
  input logic       lock_o,
  input logic       code_err_i
);
  localparam int CNT_W = $clog2(WORD_CHARS + 1);
  logic [CNT_W-1:0] since_ws;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           since_ws <= '0;
    else if (!lock_o)                                      since_ws <= '0;
    else if (word_start_o)                                 since_ws <= CNT_W'(1);
    else if (since_ws != '0 && since_ws < CNT_W'(WORD_CHARS)) since_ws <= since_ws + 1'b1;
  end

  AST_WS_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_start_o |-> lock_o); // R7

  AST_WS_ON_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && since_ws == CNT_W'(WORD_CHARS)) |-> word_start_o); // R7

  AST_WS_NOT_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_start_o && since_ws != '0) |-> since_ws == CNT_W'(WORD_CHARS)); // R7

  AST_LOCK_ON_COMMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (word_start_o && is_comma(char_o))); // R4

  AST_LOSS_AFTER_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> $past(word_start_o && (code_err_i || !is_comma(char_o)))); // R8
endmodule

bind comma_word_aligner comma_word_aligner_chk #(.WORD_CHARS(WORD_CHARS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .char_o       (char_o),
  .word_start_o (word_start_o),
  .lock_o       (lock_o),
  .code_err_i   (code_err_i)
);

// File: tb/comma_word_aligner_tb.sv
`timescale 1ns/1ps
module comma_word_aligner_tb;
  localparam int MAXB = 4096;
  localparam logic [9:0] C_NEG = 10'b0011111010;
  localparam logic [9:0] C_POS = 10'b1100000101;
  localparam logic [9:0] D_A   = 10'b1010101010;
  localparam logic [9:0] D_B   = 10'b0101010101;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] data_i = '0;
  logic       code_err_i = 1'b0;
  logic [9:0] char_o;
  logic       word_start_o, lock_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  comma_word_aligner u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .code_err_i(code_err_i),
    .char_o(char_o), .word_start_o(word_start_o), .lock_o(lock_o)
  );

  logic bits [0:MAXB-1];
  int   nb = 0;

  // bench model state: 0 hunt, 1 confirm, 2 sync
  int         m_st = 0, m_off = 0, m_pos = 0, m_good = 0, m_bad = 0;
  logic [9:0] e_char = '0;
  logic       e_ws = 0, e_lock = 0;

  function automatic bit comma(logic [9:0] c);
    return (c == C_NEG) || (c == C_POS);
  endfunction

  function automatic logic [9:0] char_at(int n, int k);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) begin
      int idx = 10*(n-1) + k + i;
      r[9-i] = (idx < 0) ? 1'b0 : bits[idx];
    end
    return r;
  endfunction

  function automatic logic [9:0] chunk(int n);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[9-i] = bits[10*n + i];
    return r;
  endfunction

  function automatic bit err_ord(int o);
    return (o >= 5 && o <= 7) || (o >= 9 && o <= 12);
  endfunction

  task automatic put_char(logic [9:0] c);
    for (int i = 9; i >= 0; i--) begin bits[nb] = c[i]; nb++; end
  endtask

  task automatic put_junk(int k);
    for (int i = 0; i < k; i++) begin bits[nb] = ~i[0]; nb++; end
  endtask

  task automatic put_word(bit good);
    logic [9:0] cm;
    cm = ($urandom % 2) ? C_POS : C_NEG;
    put_char(good ? cm : D_A);
    for (int i = 0; i < 3; i++) put_char(($urandom % 2) ? D_A : D_B);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_step(int n, logic err);
    int nst, noff, npos, ngood, nbad, hk;
    logic [9:0] ch;
    ch = char_at(n, m_off);
    nst = m_st; noff = m_off; ngood = m_good; nbad = m_bad;
    npos = (m_pos == 3) ? 0 : m_pos + 1;
    case (m_st)
      0: begin
        npos = 0; hk = -1;
        for (int k = 9; k >= 0; k--) if (comma(char_at(n, k))) hk = k;
        if (hk >= 0) begin noff = hk; npos = 1; ngood = 1; nst = 1; end
      end
      1: if (m_pos == 0) begin
        if (!comma(ch)) nst = 0;
        else if (m_good == 2) begin nst = 2; nbad = 0; end
        else ngood = m_good + 1;
      end
      default: if (e_ws) begin
        if (!(err || !comma(e_char))) nbad = 0;
        else if (m_bad == 3) nst = 0;
        else nbad = m_bad + 1;
      end
    endcase
    e_ws   = (nst == 2) && (m_st != 0) && (m_pos == 0);
    e_lock = (nst == 2);
    e_char = ch;
    m_st = nst; m_off = noff; m_pos = npos; m_good = ngood; m_bad = nbad;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ncyc, ord, rises, falls, first_rise, exp_rise;
    logic prev_lock, err;
    void'($urandom(32'h5eed_0a11));
    for (int i = 0; i < MAXB; i++) bits[i] = 1'b0;

    // stream: junk, 2 good words, broken word, 20 good, 3-bit slip, 12 good
    put_junk(10 + ($urandom % 10));
    put_char(D_A); put_char(D_B);
    put_word(1); put_word(1); put_word(0);
    put_word(1); put_word(1);
    exp_rise = nb / 10 + 2;
    for (int w = 0; w < 18; w++) put_word(1);
    put_junk(3);
    for (int w = 0; w < 12; w++) put_word(1);
    put_junk(30);
    ncyc = nb / 10 - 1;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(char_o == 0, "R1 char_o", char_o, 0);
    chk(word_start_o == 0, "R1 word_start_o", word_start_o, 0);
    chk(lock_o == 0, "R1 lock_o", lock_o, 0);
    rst_ni = 1'b1;

    ord = 0; rises = 0; falls = 0; first_rise = -1; prev_lock = 0;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      chk(lock_o == e_lock, "R4 R9 lock_o", lock_o, e_lock);
      chk(word_start_o == e_ws, "R2 R7 word_start_o", word_start_o, e_ws);
      if (e_lock) chk(char_o == e_char, "R6 char_o", char_o, e_char);
      if (lock_o && !prev_lock) begin
        rises++;
        if (first_rise < 0) first_rise = n;
      end
      if (!lock_o && prev_lock) falls++;
      prev_lock = lock_o;
      if (e_ws) begin ord++; err = err_ord(ord); end
      else err = ($urandom % 2);  // R8: ignored off word starts
      data_i = chunk(n);
      code_err_i = err;
      model_step(n, err);
    end
    @(negedge clk);
    chk(first_rise == exp_rise, "R4 R5 first lock cycle", first_rise, exp_rise);
    chk(falls == 2, "R8 lock losses", falls, 2);
    chk(rises == 3, "R9 lock acquisitions", rises, 3);
    chk(lock_o == 1, "R3 relocked at new offset", lock_o, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule